// File: doc/BRIEF.md
# Parallel ADC Burst Capture Sequencer

This block drives a 12-bit SAR converter that has a parallel data bus. It uses three registered active-low strobes: conversion start, chip select and read. It watches the converter's BUSY output. After reset it runs a check on the converter's combined power-down/reset pin. It drives the pin low for a short window and reads the bus during that window. It then compares the word it read with a fixed signature. A wrong word leaves the block in a fault state, and it never starts a conversion there.

Once the check has passed, a single trigger pulse starts a burst of back-to-back sample cycles. Each cycle starts a conversion and waits for the synchronized falling edge of BUSY. It then reads the result while the next acquisition is running and hands the word downstream on a valid/ready stream. The final word of a burst carries a last flag. All strobe widths, windows and waits are counted in system clocks and set by parameters. The defaults assume a 100 MHz clock.

Stream rules: `s_data` and `s_last` are held stable while `s_valid` is high and `s_ready` is low. A word moves on any clock edge where both are high. The output holds a single word. The block does not start a new conversion while a word is still waiting, so a slow consumer stretches the sample period and no data is lost.

Top module: `adc_burst_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `adc_convst_n`, `adc_cs_n`, `adc_rd_n` and `adc_pwd_rst` are 1, `s_valid`, `armed`, `fault_sig` and `fault_tmo` are 0.
- R2: After reset, `adc_pwd_rst` stays high for about RST_HI_CYC cycles and then goes low for exactly RST_LO_CYC cycles, which is fewer than RST_LO_MAX_CYC. `adc_cs_n` and `adc_rd_n` are low throughout that low window. The pin then stays high.
- R3: If the bus word sampled at the end of the low window equals SIG_WORD (default 0xFE0), the block becomes `armed` (1) with `fault_sig` at 0.
- R4: If that word differs, `fault_sig` goes to 1 and stays there until reset, `armed` stays 0, and a trigger starts no conversion.
- R5: A one-cycle `trigger` while armed runs exactly BURST_LEN conversions. Each cycle holds `adc_convst_n` low for CONVST_LO_CYC cycles, waits for BUSY to fall and reads the bus with `adc_cs_n`/`adc_rd_n` low for RD_CYC cycles. The bus value is delivered on `s_data`, in conversion order.
- R6: `s_last` is 1 on the final word of a burst and 0 on every other word.
- R7: Successive falling edges of `adc_convst_n` are at least PERIOD_CYC cycles apart.
- R8: `adc_rd_n` is never low in a cycle where `adc_convst_n` is low, so a readout can only overlap the acquisition phase.
- R9: While `s_valid` is 1 and `s_ready` is 0, `s_data` and `s_last` hold their values. No new conversion starts while a word is waiting, and no word is lost or repeated.
- R10: A `trigger` that arrives while a burst is running is ignored, so the burst still delivers exactly BURST_LEN words.
- R11: If BUSY has not fallen TMO_CYC cycles after a conversion start, the burst ends with no further word, `fault_tmo` goes to 1 and the block is armed again. The next accepted trigger clears `fault_tmo`.
- R12: `adc_byte` is always 0 (full-word readout) and `adc_apd_n` is always 1 (analog power-down kept off).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | One-cycle request to start a burst |
| armed | output | 1 | Signature check passed and no burst running |
| fault_sig | output | 1 | Signature check failed (sticky until reset) |
| fault_tmo | output | 1 | The last burst was cut short by a BUSY timeout |
| adc_convst_n | output | 1 | Conversion start strobe, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_pwd_rst | output | 1 | Combined power-down/reset pin, low during the check window |
| adc_byte | output | 1 | Byte select, held 0 |
| adc_apd_n | output | 1 | Analog power-down, held 1 (inactive) |
| adc_busy | input | 1 | Converter BUSY, asynchronous |
| adc_data | input | 12 | Converter parallel data bus, asynchronous |
| s_valid | output | 1 | Stream word valid |
| s_ready | input | 1 | Stream consumer ready |
| s_data | output | 12 | Stream sample word |
| s_last | output | 1 | Final word of the burst |

## Verification
The bench models the converter. It raises BUSY after each start strobe and publishes a distinct computed word when BUSY falls, so words that are dropped, repeated or taken from the wrong read show up as mismatches. The model converts fast, so the start-to-start spacing is set by the period limit alone. A design that fails to gate on that limit would start too early. A design that ignores back-pressure would start a second conversion, or overwrite the waiting word, while `s_ready` is held low. The bench also stops BUSY entirely, which would hang a design with no timeout. It retriggers mid-burst, which would lengthen the burst in a design that does not ignore it. Finally it forces a wrong signature, where a design that skips the check would go on and sample.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    S_RST_HI,   // reset pin held high after power-up
    S_RST_LO,   // reset pin low, signature read in progress
    S_FAULT,    // signature mismatch, parked
    S_IDLE,     // armed, waiting for a trigger
    S_GAP,      // waiting for period limit and a free output slot
    S_CONV,     // conversion start strobe low
    S_WAIT,     // waiting for BUSY to fall
    S_READ      // cs/rd low, result being captured
  } seq_state_e;

endpackage

// File: rtl/adc_down_timer.sv
module adc_down_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= W'(RST_VAL);
    else if (load)        cnt_q <= val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // Once run out, the timer stays run out until reloaded (supports R7, R11).
  assert_timer_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !load |=> expired);

endmodule

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_raw,
  input  logic [DW-1:0] data_raw,
  output logic          busy_fall,
  output logic [DW-1:0] data_s
);

  logic          busy_m, busy_s, busy_d;
  logic [DW-1:0] data_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_m <= 1'b0;
      busy_s <= 1'b0;
      busy_d <= 1'b0;
      data_m <= '0;
      data_s <= '0;
    end else begin
      busy_m <= busy_raw;
      busy_s <= busy_m;
      busy_d <= busy_s;
      data_m <= data_raw;
      data_s <= data_m;
    end
  end

  assign busy_fall = busy_d & ~busy_s;

  // A detected falling edge is a single-cycle event (R5).
  assert_fall_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_fall |=> !busy_fall);

endmodule

// File: rtl/adc_stream_reg.sv
module adc_stream_reg #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_last,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      last  <= 1'b0;
    end else if (push) begin
      valid <= 1'b1;
      data  <= push_data;
      last  <= push_last;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // A word is only captured into an empty slot (R9).
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !valid);

  // A stalled word keeps its contents (R9).
  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(data) && $stable(last));

endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
  import adc_seq_pkg::*;
#(
  parameter int           DW             = 12,
  parameter logic [11:0]  SIG_WORD       = 12'hFE0,
  parameter int           BURST_LEN      = 10,
  parameter int           RST_HI_CYC     = 300,
  parameter int           RST_LO_CYC     = 40,
  parameter int           RST_LO_MAX_CYC = 614,
  parameter int           CONVST_LO_CYC  = 3,
  parameter int           RD_CYC         = 4,
  parameter int           PERIOD_CYC     = 34,
  parameter int           TMO_CYC        = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trigger,
  output logic          armed,
  output logic          fault_sig,
  output logic          fault_tmo,
  output logic          adc_convst_n,
  output logic          adc_cs_n,
  output logic          adc_rd_n,
  output logic          adc_pwd_rst,
  output logic          adc_byte,
  output logic          adc_apd_n,
  input  logic          adc_busy,
  input  logic [DW-1:0] adc_data,
  output logic          s_valid,
  input  logic          s_ready,
  output logic [DW-1:0] s_data,
  output logic          s_last
);

  localparam int TW = $clog2(RST_HI_CYC + RST_LO_CYC + TMO_CYC + PERIOD_CYC + 2) + 1;
  localparam int BW = $clog2(BURST_LEN + 1) + 1;
  localparam int LW = $clog2(RST_LO_MAX_CYC + 2) + 1;

  seq_state_e    state_q, state_d;
  logic          busy_fall;
  logic [DW-1:0] data_s;

  logic          ph_load, ph_exp;
  logic [TW-1:0] ph_val;
  logic          per_load, per_exp;
  logic          tmo_load, tmo_exp;

  logic [BW-1:0] remain_q, remain_d;
  logic          tmo_flag_q, tmo_flag_d;
  logic          push, out_free;

  logic          convst_q, rdcs_q, pwd_q;

  // ---------------------------------------------------------------- inputs
  adc_in_sync #(.DW(DW)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_raw  (adc_busy),
    .data_raw  (adc_data),
    .busy_fall (busy_fall),
    .data_s    (data_s)
  );

  // ---------------------------------------------------------------- timers
  adc_down_timer #(.W(TW), .RST_VAL(RST_HI_CYC - 1)) u_phase_tmr (
    .clk (clk), .rst_n (rst_n), .load (ph_load), .val (ph_val), .expired (ph_exp)
  );

  adc_down_timer #(.W(TW), .RST_VAL(0)) u_period_tmr (
    .clk (clk), .rst_n (rst_n), .load (per_load),
    .val (TW'(PERIOD_CYC - 1)), .expired (per_exp)
  );

  adc_down_timer #(.W(TW), .RST_VAL(0)) u_tmo_tmr (
    .clk (clk), .rst_n (rst_n), .load (tmo_load),
    .val (TW'(TMO_CYC - 1)), .expired (tmo_exp)
  );

  // ---------------------------------------------------------------- sequencer
  assign out_free = !s_valid || s_ready;

  always_comb begin
    state_d    = state_q;
    ph_load    = 1'b0;
    ph_val     = '0;
    per_load   = 1'b0;
    tmo_load   = 1'b0;
    remain_d   = remain_q;
    tmo_flag_d = tmo_flag_q;
    push       = 1'b0;
    unique case (state_q)
      S_RST_HI: begin
        if (ph_exp) begin
          state_d = S_RST_LO;
          ph_load = 1'b1;
          ph_val  = TW'(RST_LO_CYC - 1);
        end
      end
      S_RST_LO: begin
        if (ph_exp) state_d = (data_s == DW'(SIG_WORD)) ? S_IDLE : S_FAULT;
      end
      S_FAULT: state_d = S_FAULT;
      S_IDLE: begin
        if (trigger) begin
          state_d    = S_GAP;
          remain_d   = BW'(BURST_LEN);
          tmo_flag_d = 1'b0;
        end
      end
      S_GAP: begin
        if (per_exp && out_free) begin
          state_d  = S_CONV;
          ph_load  = 1'b1;
          ph_val   = TW'(CONVST_LO_CYC - 1);
          per_load = 1'b1;
          tmo_load = 1'b1;
        end
      end
      S_CONV: begin
        if (ph_exp) state_d = S_WAIT;
      end
      S_WAIT: begin
        if (busy_fall) begin
          state_d = S_READ;
          ph_load = 1'b1;
          ph_val  = TW'(RD_CYC - 1);
        end else if (tmo_exp) begin
          state_d    = S_IDLE;
          remain_d   = '0;
          tmo_flag_d = 1'b1;
        end
      end
      S_READ: begin
        if (ph_exp) begin
          push     = 1'b1;
          remain_d = remain_q - 1'b1;
          state_d  = (remain_q == BW'(1)) ? S_IDLE : S_GAP;
        end
      end
      default: state_d = S_FAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_RST_HI;
      remain_q   <= '0;
      tmo_flag_q <= 1'b0;
      convst_q   <= 1'b1;
      rdcs_q     <= 1'b1;
      pwd_q      <= 1'b1;
    end else begin
      state_q    <= state_d;
      remain_q   <= remain_d;
      tmo_flag_q <= tmo_flag_d;
      convst_q   <= (state_d != S_CONV);
      rdcs_q     <= !((state_d == S_READ) || (state_d == S_RST_LO));
      pwd_q      <= (state_d != S_RST_LO);
    end
  end

  assign adc_convst_n = convst_q;
  assign adc_cs_n     = rdcs_q;
  assign adc_rd_n     = rdcs_q;
  assign adc_pwd_rst  = pwd_q;
  assign adc_byte     = 1'b0;
  assign adc_apd_n    = 1'b1;
  assign armed        = (state_q == S_IDLE);
  assign fault_sig    = (state_q == S_FAULT);
  assign fault_tmo    = tmo_flag_q;

  // ---------------------------------------------------------------- output
  adc_stream_reg #(.DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (data_s),
    .push_last (remain_q == BW'(1)),
    .ready     (s_ready),
    .valid     (s_valid),
    .data      (s_data),
    .last      (s_last)
  );

  // ---------------------------------------------------------------- checks
  logic [TW-1:0] since_start_q;
  logic          cv_prev_q;
  logic [LW-1:0] lo_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_start_q <= TW'(PERIOD_CYC);
      cv_prev_q     <= 1'b1;
      lo_run_q      <= '0;
    end else begin
      cv_prev_q <= adc_convst_n;
      if (cv_prev_q && !adc_convst_n)               since_start_q <= TW'(1);
      else if (since_start_q < TW'(PERIOD_CYC))     since_start_q <= since_start_q + 1'b1;
      if (adc_pwd_rst)                              lo_run_q <= '0;
      else if (lo_run_q < LW'(RST_LO_MAX_CYC + 1))  lo_run_q <= lo_run_q + 1'b1;
    end
  end

  assert_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cv_prev_q && !adc_convst_n |-> since_start_q >= TW'(PERIOD_CYC));

  assert_rst_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run_q < LW'(RST_LO_MAX_CYC));

  assert_read_not_in_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!adc_rd_n && !adc_convst_n));

  assert_fault_parked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_sig |=> fault_sig && adc_convst_n);

  assert_tmo_rearms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_tmo) |-> armed && !s_valid);

endmodule

// File: tb/adc_burst_seq_bench.sv
module adc_burst_seq_bench;

  localparam int BL      = 10;
  localparam int RST_HI  = 50;
  localparam int RST_LO  = 20;
  localparam int LO_MAX  = 614;
  localparam int PERIOD  = 34;
  localparam int TMO     = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trigger = 1'b0;
  logic        s_ready = 1'b1;
  logic        armed, fault_sig, fault_tmo;
  logic        adc_convst_n, adc_cs_n, adc_rd_n, adc_pwd_rst, adc_byte, adc_apd_n;
  logic        s_valid, s_last;
  logic [11:0] s_data;
  logic [11:0] adc_data;

  always #5 clk = ~clk;

  // ------------------------------------------------------------ converter model
  logic [11:0] sig_word  = 12'hFE0;
  logic        busy_dead = 1'b0;
  logic        mbusy     = 1'b0;
  int          mcnt      = 0;
  int          conv_idx  = 0;
  logic [11:0] mresult   = 12'h000;
  logic        mcv_q     = 1'b1;

  function automatic logic [11:0] fval(input int n);
    return 12'(32'h123 + n * 167);
  endfunction

  always @(posedge clk) begin
    mcv_q <= adc_convst_n;
    if (mcv_q && !adc_convst_n && !busy_dead) begin
      mbusy <= 1'b1;
      mcnt  <= 10;
    end else if (mbusy) begin
      if (mcnt == 1) begin
        mbusy    <= 1'b0;
        mresult  <= fval(conv_idx);
        conv_idx <= conv_idx + 1;
      end
      mcnt <= mcnt - 1;
    end
  end

  assign adc_data = !adc_pwd_rst ? sig_word :
                    (!adc_cs_n && !adc_rd_n) ? mresult : 12'h000;

  adc_burst_seq #(
    .BURST_LEN (BL), .RST_HI_CYC (RST_HI), .RST_LO_CYC (RST_LO),
    .RST_LO_MAX_CYC (LO_MAX), .PERIOD_CYC (PERIOD), .TMO_CYC (TMO)
  ) u_adc_burst_seq (
    .clk (clk), .rst_n (rst_n), .trigger (trigger), .armed (armed),
    .fault_sig (fault_sig), .fault_tmo (fault_tmo),
    .adc_convst_n (adc_convst_n), .adc_cs_n (adc_cs_n), .adc_rd_n (adc_rd_n),
    .adc_pwd_rst (adc_pwd_rst), .adc_byte (adc_byte), .adc_apd_n (adc_apd_n),
    .adc_busy (mbusy), .adc_data (adc_data),
    .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data), .s_last (s_last)
  );

  // ------------------------------------------------------------ bookkeeping
  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int conv_falls = 0;
  int last_fall = -100000;
  int viol_period = 0, viol_excl = 0, viol_static = 0, viol_hold = 0;
  int got_cnt = 0;
  logic [11:0] got_data [64];
  logic        got_last [64];
  logic        prev_cv = 1'b1;
  logic        prev_stall = 1'b0;
  logic [11:0] prev_data = 12'h000;
  logic        prev_last = 1'b0;

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_fall = -100000;
      prev_cv   = 1'b1;
      prev_stall = 1'b0;
    end else begin
      if (prev_cv && !adc_convst_n) begin
        conv_falls++;
        if (cyc - last_fall < PERIOD) viol_period++;
        last_fall = cyc;
      end
      prev_cv = adc_convst_n;
      if (!adc_rd_n && !adc_convst_n) viol_excl++;
      if (prev_stall && !(s_valid && s_data == prev_data && s_last == prev_last)) viol_hold++;
      prev_stall = s_valid && !s_ready;
      prev_data  = s_data;
      prev_last  = s_last;
      if (s_valid && s_ready && got_cnt < 64) begin
        got_data[got_cnt] = s_data;
        got_last[got_cnt] = s_last;
        got_cnt++;
      end
    end
    if (adc_byte !== 1'b0 || adc_apd_n !== 1'b1) viol_static++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic pulse_trigger();
    @(negedge clk) trigger = 1'b1;
    @(negedge clk) trigger = 1'b0;
  endtask

  task automatic wait_words(input int n);
    for (int i = 0; i < 3000 && got_cnt < n; i++) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  task automatic check_burst(input string req, input int base);
    chk({req, " word count"}, got_cnt == BL, got_cnt, BL);
    for (int k = 0; k < BL && k < got_cnt; k++) begin
      chk({req, " R5 data"}, got_data[k] == fval(base + k), got_data[k], fval(base + k));
      chk({req, " R6 last"}, got_last[k] == (k == BL - 1), got_last[k], (k == BL - 1));
    end
  endtask

  // ------------------------------------------------------------ scenarios
  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", adc_convst_n && adc_cs_n && adc_rd_n && adc_pwd_rst, 0, 1);
    chk("R1 flags in reset", !s_valid && !armed && !fault_sig && !fault_tmo, 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle", adc_convst_n && adc_pwd_rst && !s_valid && !armed, 0, 1);
  endtask

  task automatic t_reset_seq();
    int hi = 1;
    int lo = 0;
    int rd_bad = 0;
    while (adc_pwd_rst && hi < 1000) begin @(negedge clk); hi++; end
    while (!adc_pwd_rst && lo < 1000) begin
      if (adc_cs_n || adc_rd_n) rd_bad++;
      @(negedge clk); lo++;
    end
    chk("R2 high phase", hi >= RST_HI - 2 && hi <= RST_HI + 2, hi, RST_HI);
    chk("R2 low window", lo == RST_LO, lo, RST_LO);
    chk("R2 below limit", lo < LO_MAX, lo, LO_MAX);
    chk("R2 read strobes in window", rd_bad == 0, rd_bad, 0);
    repeat (5) @(negedge clk);
    chk("R3 armed", armed && !fault_sig, {armed, fault_sig}, 2);
    chk("R2 pin high after", adc_pwd_rst, adc_pwd_rst, 1);
  endtask

  task automatic t_burst();
    int base = conv_idx;
    int f0 = conv_falls;
    got_cnt = 0;
    pulse_trigger();
    wait_words(BL);
    check_burst("R5 burst", base);
    chk("R5 conversion count", conv_falls - f0 == BL, conv_falls - f0, BL);
    chk("R5 armed after", armed, armed, 1);
  endtask

  task automatic t_retrigger();
    int base = conv_idx;
    got_cnt = 0;
    pulse_trigger();
    repeat (100) @(negedge clk);
    pulse_trigger();
    wait_words(BL);
    repeat (200) @(negedge clk);
    check_burst("R10 retrigger", base);
  endtask

  task automatic t_backpressure();
    int base = conv_idx;
    int f0 = conv_falls;
    got_cnt = 0;
    s_ready = 1'b0;
    pulse_trigger();
    repeat (300) @(negedge clk);
    chk("R9 one start while stalled", conv_falls - f0 == 1, conv_falls - f0, 1);
    chk("R9 word waiting", s_valid, s_valid, 1);
    chk("R9 waiting data", s_data == fval(base), s_data, fval(base));
    for (int i = 0; i < 3000 && got_cnt < BL; i++) begin
      @(negedge clk);
      s_ready = (cyc % 3) != 0;
    end
    s_ready = 1'b1;
    repeat (60) @(negedge clk);
    check_burst("R9 stalled burst", base);
  endtask

  task automatic t_timeout();
    int f0 = conv_falls;
    int base;
    got_cnt = 0;
    busy_dead = 1'b1;
    pulse_trigger();
    repeat (TMO + 80) @(negedge clk);
    chk("R11 fault flag", fault_tmo, fault_tmo, 1);
    chk("R11 rearmed", armed, armed, 1);
    chk("R11 no word", got_cnt == 0, got_cnt, 0);
    chk("R11 burst aborted", conv_falls - f0 == 1, conv_falls - f0, 1);
    busy_dead = 1'b0;
    base = conv_idx;
    pulse_trigger();
    repeat (2) @(negedge clk);
    chk("R11 cleared by trigger", !fault_tmo, fault_tmo, 0);
    wait_words(BL);
    check_burst("R11 recovery", base);
  endtask

  task automatic t_bad_sig();
    int f0;
    sig_word = 12'hABC;
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (RST_HI + RST_LO + 10) @(negedge clk);
    chk("R4 fault flag", fault_sig, fault_sig, 1);
    chk("R4 not armed", !armed, armed, 0);
    f0 = conv_falls;
    pulse_trigger();
    repeat (200) @(negedge clk);
    chk("R4 no conversion", conv_falls == f0, conv_falls - f0, 0);
    chk("R4 fault sticky", fault_sig, fault_sig, 1);
  endtask

  initial begin
    t_reset_state();
    t_reset_seq();
    t_burst();
    t_retrigger();
    t_backpressure();
    t_timeout();
    chk("R7 start spacing", viol_period == 0, viol_period, 0);
    chk("R8 read outside conversion", viol_excl == 0, viol_excl, 0);
    chk("R9 stall hold", viol_hold == 0, viol_hold, 0);
    t_bad_sig();
    chk("R12 static pins", viol_static == 0, viol_static, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule